// File: doc/BRIEF.md
# Display Raster Timing and Position Counters

This block produces the horizontal and vertical timing of a progressive display raster from a set of programmable mode values. It drives horizontal sync, vertical sync, active-video and vertical-blank levels, plus three single-cycle strobes: start of vertical blank, frame start, and start of vertical sync. Most line events are tied to the leading edge of horizontal sync, not to the first active pixel.

It also keeps the position counters that a display driver polls. There is a scanline counter that runs one line behind the line being output, a pixel-in-frame counter, a 24-bit frame counter, and a copy of a free-running timestamp taken at every start of vertical blank. Mode writes land in shadow copies and reach the live timing only at the start of vertical blank. Reads return a 32-bit word one clock after the request. The frame count can be read as the upper half of a coherent 64-bit pair whose lower half is the pixel count.

All level and strobe outputs are registered. Each one reflects the raster position of the previous clock. In the requirements, "position (h, l)" means the internal horizontal count h and output line l. Both start at 0 on the first active pixel of a frame.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high, every output (levels, strobes and rd_data) is 0. Reset clears the position, scanline, pixel, frame and timestamp counters to 0.
- R2: h runs from 0 to htotal-1 and then l advances, wrapping after vtotal-1. hsync_o is high for positions with hsync_start <= h < hsync_end. active_o is high for h < hdisplay and l < vblank_start. vblank_o is high for vblank_start <= l < vblank_end.
- R3: The scanline counter takes the value l at the position h = hsync_start of line l. On line 0 before that point it therefore reads vtotal-1, and just after start of vertical blank it reads vblank_start-1.
- R4: vbl_stb_o pulses for one cycle for position (hsync_start, vblank_start-1). In that same cycle the frame counter has been incremented by one, modulo 2^24.
- R5: fs_stb_o pulses for one cycle for position (hdisplay, (vblank_start+d) mod vtotal). d is the 2-bit frame-start delay, written at address 9 in bits [1:0]. Frame start therefore lands 1 to 4 lines after start of vertical blank.
- R6: vs_stb_o pulses for position (hsync_start, vsync_start-1). vsync_o rises with it and falls for position (hsync_start, vsync_end-1).
- R7: The pixel counter is 0 at position (0, 0) and counts one per clock through the frame. At position (0, vblank_start) it reads vblank_start*htotal.
- R8: At each start of vertical blank, the frame timestamp takes the free-running timestamp value, which counts clocks since reset. That value is the number of clocks since reset at that edge, minus one.
- R9: A write to address 0..9 (htotal, hdisplay, hsync_start, hsync_end, vtotal, vblank_start, vblank_end, vsync_start, vsync_end, frame-start delay) changes only a shadow copy. The timing changes only from the next start of vertical blank.
- R10: A read of address 0 returns the pixel counter and captures the frame counter. A later read of address 1 returns that captured value, even if the frame counter has moved since.
- R11: A read with rd_en high returns data on rd_data one clock later: address 2 gives the scanline, 3 the frame timestamp, 4 the live frame counter, and any other address gives 0. Without rd_en, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode shadow write strobe |
| wr_addr | input | 4 | Mode field select (0..9) |
| wr_data | input | CNT_W (12) | Mode field value |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read select (0..4) |
| rd_data | output | 32 | Read data, one cycle after request |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| active_o | output | 1 | Active video level |
| vblank_o | output | 1 | Vertical blank level |
| vbl_stb_o | output | 1 | Start of vertical blank strobe |
| fs_stb_o | output | 1 | Frame start strobe |
| vs_stb_o | output | 1 | Start of vertical sync strobe |

## Verification
The bench builds the block with a tiny mode: htotal 16, hdisplay 8, hsync 10..12, vtotal 7, vblank from line 4 to the end, and vsync on lines 5..6. These values follow the pattern vsync_start = vblank_start+1, vsync_end = vblank_start+2, vtotal = vblank_start+3. One frame is 112 clocks, so dozens of frames, every frame-start delay including the one that wraps to line 0, and a mid-run change of vtotal to 9 all fit in a short run. Every level and strobe is compared on every cycle with a model, and random reads hit each counter at arbitrary raster positions. A read is also placed directly on the edge where the frame counter increments, to test the coherent pair.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int CNT_W = 12;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t       htotal;
    cnt_t       hdisp;
    cnt_t       hss;
    cnt_t       hse;
    cnt_t       vtotal;
    cnt_t       vbs;
    cnt_t       vbe;
    cnt_t       vss;
    cnt_t       vse;
    logic [1:0] fs_dly;
  } mode_t;

  typedef enum logic [3:0] {
    W_HTOTAL = 4'd0, W_HDISP, W_HSS, W_HSE, W_VTOTAL,
    W_VBS, W_VBE, W_VSS, W_VSE, W_FSDLY
  } wr_sel_e;

  typedef enum logic [2:0] {
    R_PIX_LO = 3'd0, R_FRAME_HI, R_SCAN, R_TSTAMP, R_FRAME
  } rd_sel_e;
endpackage

// File: rtl/raster_mode_regs.sv
module raster_mode_regs
  import raster_pkg::*;
#(
  parameter mode_t RESET_MODE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             latch_i,
  output mode_t            act_o
);
  mode_t shadow_q;
  mode_t act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RESET_MODE;
      act_q    <= RESET_MODE;
    end else begin
      if (latch_i) act_q <= shadow_q;
      if (wr_en) begin
        case (wr_sel_e'(wr_addr))
          W_HTOTAL: shadow_q.htotal <= wr_data;
          W_HDISP:  shadow_q.hdisp  <= wr_data;
          W_HSS:    shadow_q.hss    <= wr_data;
          W_HSE:    shadow_q.hse    <= wr_data;
          W_VTOTAL: shadow_q.vtotal <= wr_data;
          W_VBS:    shadow_q.vbs    <= wr_data;
          W_VBE:    shadow_q.vbe    <= wr_data;
          W_VSS:    shadow_q.vss    <= wr_data;
          W_VSE:    shadow_q.vse    <= wr_data;
          W_FSDLY:  shadow_q.fs_dly <= wr_data[1:0];
          default:  ;
        endcase
      end
    end
  end

  assign act_o = act_q;

  // R9: live timing only moves on the vblank latch
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !latch_i |=> $stable(act_q));
endmodule

// File: rtl/raster_hv_counter.sv
module raster_hv_counter
  import raster_pkg::*;
#(
  parameter int PIX_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_t             htotal,
  input  cnt_t             vtotal,
  output cnt_t             h_o,
  output cnt_t             l_o,
  output logic [PIX_W-1:0] pix_o
);
  cnt_t h_q, l_q;
  logic [PIX_W-1:0] pix_q;
  logic end_h, end_v;

  assign end_h = (h_q >= htotal - cnt_t'(1));
  assign end_v = (l_q >= vtotal - cnt_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q   <= '0;
      l_q   <= '0;
      pix_q <= '0;
    end else begin
      h_q   <= end_h ? '0 : h_q + cnt_t'(1);
      if (end_h) l_q <= end_v ? '0 : l_q + cnt_t'(1);
      pix_q <= (end_h && end_v) ? '0 : pix_q + PIX_W'(1);
    end
  end

  assign h_o   = h_q;
  assign l_o   = l_q;
  assign pix_o = pix_q;

  // R2: the line index only moves when a new line begins
  p_line_at_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (l_q != $past(l_q)) |-> (h_q == '0));
  // R7: pixel count is zero at the frame origin
  p_pix_origin_r7: assert property (@(posedge clk) disable iff (rst)
    (h_q == '0 && l_q == '0) |-> (pix_q == '0));
endmodule

// File: rtl/raster_event_gen.sv
module raster_event_gen
  import raster_pkg::*;
#(
  parameter int FC_W = 24,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  cnt_t            h,
  input  cnt_t            l,
  input  cnt_t            hdisp,
  input  cnt_t            hss,
  input  cnt_t            hse,
  input  cnt_t            vtotal,
  input  cnt_t            vbs,
  input  cnt_t            vbe,
  input  cnt_t            vss,
  input  cnt_t            vse,
  input  logic [1:0]      fs_dly,
  output logic            latch_o,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            active_o,
  output logic            vblank_o,
  output logic            vbl_stb_o,
  output logic            fs_stb_o,
  output logic            vs_stb_o,
  output cnt_t            scan_o,
  output logic [FC_W-1:0] frame_o,
  output logic [TS_W-1:0] ts_lat_o
);
  logic tick, vbl_ev, vs_on, vs_off, fs_ev;
  logic [CNT_W:0] fs_sum;
  cnt_t fs_line;

  assign tick   = (h == hss);
  assign vbl_ev = tick && (l == vbs - cnt_t'(1));
  assign vs_on  = tick && (l == vss - cnt_t'(1));
  assign vs_off = tick && (l == vse - cnt_t'(1));
  assign fs_sum = {1'b0, vbs} + {{(CNT_W-1){1'b0}}, fs_dly};
  assign fs_line = (fs_sum >= {1'b0, vtotal}) ? cnt_t'(fs_sum - {1'b0, vtotal})
                                              : fs_sum[CNT_W-1:0];
  assign fs_ev  = (h == hdisp) && (l == fs_line);
  assign latch_o = vbl_ev;

  logic hs_q, vs_q, act_q, vb_q, vbl_q, fs_q, vss_q;
  cnt_t scan_q;
  logic [FC_W-1:0] frame_q;
  logic [TS_W-1:0] ts_q, ts_lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0; vs_q <= 1'b0; act_q <= 1'b0; vb_q <= 1'b0;
      vbl_q <= 1'b0; fs_q <= 1'b0; vss_q <= 1'b0;
      scan_q <= '0; frame_q <= '0; ts_q <= '0; ts_lat_q <= '0;
    end else begin
      hs_q  <= (h >= hss) && (h < hse);
      act_q <= (h < hdisp) && (l < vbs);
      vb_q  <= (l >= vbs) && (l < vbe);
      vbl_q <= vbl_ev;
      fs_q  <= fs_ev;
      vss_q <= vs_on;
      if (vs_on)       vs_q <= 1'b1;
      else if (vs_off) vs_q <= 1'b0;
      if (tick) scan_q <= l;
      ts_q <= ts_q + TS_W'(1);
      if (vbl_ev) begin
        frame_q  <= frame_q + FC_W'(1);
        ts_lat_q <= ts_q;
      end
    end
  end

  assign hsync_o   = hs_q;
  assign vsync_o   = vs_q;
  assign active_o  = act_q;
  assign vblank_o  = vb_q;
  assign vbl_stb_o = vbl_q;
  assign fs_stb_o  = fs_q;
  assign vs_stb_o  = vss_q;
  assign scan_o    = scan_q;
  assign frame_o   = frame_q;
  assign ts_lat_o  = ts_lat_q;

  // R4: vblank strobe lasts one cycle
  p_vbl_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    vbl_q |=> !vbl_q);
  // R4: frame counter steps with the vblank strobe
  p_frame_step_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(vbl_q) |-> (frame_q == $past(frame_q) + FC_W'(1)));
  // R8: timestamp copy is the free-running count before the edge
  p_ts_capture_r8: assert property (@(posedge clk) disable iff (rst)
    vbl_q |-> (ts_lat_q == $past(ts_q)));
  // R3: scanline only moves at the leading edge of hsync
  p_scan_on_hsync_r3: assert property (@(posedge clk) disable iff (rst)
    (scan_q != $past(scan_q)) |-> $rose(hs_q));
endmodule

// File: rtl/raster_read_port.sv
module raster_read_port
  import raster_pkg::*;
#(
  parameter int PIX_W = 2 * CNT_W,
  parameter int FC_W  = 24,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [2:0]       rd_addr,
  input  logic [PIX_W-1:0] pix,
  input  logic [FC_W-1:0]  frame,
  input  cnt_t             scan,
  input  logic [TS_W-1:0]  ts_lat,
  output logic [31:0]      rd_data
);
  logic [FC_W-1:0] hold_q;
  logic [31:0]     data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      data_q <= '0;
    end else if (rd_en) begin
      case (rd_sel_e'(rd_addr))
        R_PIX_LO: begin
          data_q <= 32'(pix);
          hold_q <= frame;
        end
        R_FRAME_HI: data_q <= 32'(hold_q);
        R_SCAN:     data_q <= 32'(scan);
        R_TSTAMP:   data_q <= 32'(ts_lat);
        R_FRAME:    data_q <= 32'(frame);
        default:    data_q <= '0;
      endcase
    end
  end

  assign rd_data = data_q;

  // R11: read data holds without a request
  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(data_q));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int FC_W    = 24,
  parameter int TS_W    = 32,
  parameter int H_TOTAL = 16,
  parameter int H_DISP  = 8,
  parameter int H_SS    = 10,
  parameter int H_SE    = 12,
  parameter int V_TOTAL = 7,
  parameter int V_BS    = 4,
  parameter int V_BE    = 7,
  parameter int V_SS    = 5,
  parameter int V_SE    = 6,
  parameter int FS_DLY  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             active_o,
  output logic             vblank_o,
  output logic             vbl_stb_o,
  output logic             fs_stb_o,
  output logic             vs_stb_o
);
  localparam int PIX_W = 2 * CNT_W;
  localparam mode_t RESET_MODE = '{
    htotal: cnt_t'(H_TOTAL), hdisp: cnt_t'(H_DISP), hss: cnt_t'(H_SS),
    hse: cnt_t'(H_SE), vtotal: cnt_t'(V_TOTAL), vbs: cnt_t'(V_BS),
    vbe: cnt_t'(V_BE), vss: cnt_t'(V_SS), vse: cnt_t'(V_SE),
    fs_dly: 2'(FS_DLY)};

  mode_t m;
  logic latch;
  cnt_t h, l, scan;
  logic [PIX_W-1:0] pix;
  logic [FC_W-1:0]  frame;
  logic [TS_W-1:0]  ts_lat;

  raster_mode_regs #(.RESET_MODE(RESET_MODE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .latch_i(latch), .act_o(m));

  raster_hv_counter #(.PIX_W(PIX_W)) u_hv (
    .clk(clk), .rst(rst), .htotal(m.htotal), .vtotal(m.vtotal),
    .h_o(h), .l_o(l), .pix_o(pix));

  raster_event_gen #(.FC_W(FC_W), .TS_W(TS_W)) u_evt (
    .clk(clk), .rst(rst), .h(h), .l(l),
    .hdisp(m.hdisp), .hss(m.hss), .hse(m.hse), .vtotal(m.vtotal),
    .vbs(m.vbs), .vbe(m.vbe), .vss(m.vss), .vse(m.vse), .fs_dly(m.fs_dly),
    .latch_o(latch), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .active_o(active_o), .vblank_o(vblank_o), .vbl_stb_o(vbl_stb_o),
    .fs_stb_o(fs_stb_o), .vs_stb_o(vs_stb_o), .scan_o(scan),
    .frame_o(frame), .ts_lat_o(ts_lat));

  raster_read_port #(.PIX_W(PIX_W), .FC_W(FC_W), .TS_W(TS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .pix(pix),
    .frame(frame), .scan(scan), .ts_lat(ts_lat), .rd_data(rd_data));
endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  localparam int HT = 16, HD = 8, HSS = 10, HSE = 12;
  localparam int VT = 7, VBS = 4, VBE = 7, VSS = 5, VSE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic hsync_o, vsync_o, active_o, vblank_o, vbl_stb_o, fs_stb_o, vs_stb_o;

  always #5 clk = ~clk;

  raster_timing_gen #(.H_TOTAL(HT), .H_DISP(HD), .H_SS(HSS), .H_SE(HSE),
    .V_TOTAL(VT), .V_BS(VBS), .V_BE(VBE), .V_SS(VSS), .V_SE(VSE)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .active_o(active_o), .vblank_o(vblank_o),
    .vbl_stb_o(vbl_stb_o), .fs_stb_o(fs_stb_o), .vs_stb_o(vs_stb_o));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int a[10], s[10];
  int mh, ml, mpix, mscan, mframe, mts, mtslat, m_hold, m_vs;
  int e_hs, e_act, e_vb, e_vbl, e_fs, e_vss;
  logic [31:0] e_rd;
  int cyc, last_vbl, vbl_gap, fs_gap, vs_gap, vbl_cyc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    int tick, vbl_ev, vs_on, vs_off, fsl, endh, endv;
    @(posedge clk);
    tick   = (mh == a[2]);
    vbl_ev = tick && (ml == a[5] - 1);
    vs_on  = tick && (ml == a[7] - 1);
    vs_off = tick && (ml == a[8] - 1);
    fsl = a[5] + a[9];
    if (fsl >= a[4]) fsl -= a[4];
    e_hs  = (mh >= a[2]) && (mh < a[3]);
    e_act = (mh < a[1]) && (ml < a[5]);
    e_vb  = (ml >= a[5]) && (ml < a[6]);
    e_vbl = vbl_ev;
    e_fs  = (mh == a[1]) && (ml == fsl);
    e_vss = vs_on;
    if (vs_on) m_vs = 1; else if (vs_off) m_vs = 0;
    if (rd_en) begin
      case (rd_addr)
        3'd0: begin e_rd = mpix; m_hold = mframe; end
        3'd1: e_rd = m_hold;
        3'd2: e_rd = mscan;
        3'd3: e_rd = mtslat;
        3'd4: e_rd = mframe;
        default: e_rd = 0;
      endcase
    end
    if (tick) mscan = ml;
    if (vbl_ev) begin mframe = (mframe + 1) & 32'hFFFFFF; mtslat = mts; end
    mts++;
    endh = (mh >= a[0] - 1);
    endv = (ml >= a[4] - 1);
    mpix = (endh && endv) ? 0 : mpix + 1;
    if (endh) ml = endv ? 0 : ml + 1;
    mh = endh ? 0 : mh + 1;
    if (vbl_ev) a = s;
    if (wr_en) s[wr_addr] = (wr_addr == 4'd9) ? (wr_data & 3) : int'(wr_data);
    cyc++;
    @(negedge clk);
    chk("R2 hsync", hsync_o, e_hs);
    chk("R2 active", active_o, e_act);
    chk("R2 vblank", vblank_o, e_vb);
    chk("R4 vbl strobe", vbl_stb_o, e_vbl);
    chk("R5 frame start", fs_stb_o, e_fs);
    chk("R6 vsync strobe", vs_stb_o, e_vss);
    chk("R6 vsync level", vsync_o, m_vs);
    chk("R11 read data", rd_data, e_rd);
    if (vbl_stb_o) begin vbl_gap = cyc - last_vbl; last_vbl = cyc; vbl_cyc = cyc; end
    if (fs_stb_o) fs_gap = cyc - last_vbl;
    if (vs_stb_o) vs_gap = cyc - last_vbl;
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      rd_en = rnd && ($urandom % 4 == 0);
      rd_addr = 3'($urandom % 6);
      step();
    end
    rd_en = 1'b0;
  endtask

  task automatic rd(int addr);
    rd_en = 1'b1; rd_addr = 3'(addr);
    step();
    rd_en = 1'b0;
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 12'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_pos(int hh, int ll);
    while (!(mh == hh && ml == ll)) step();
  endtask

  task automatic wait_vbl();
    do step(); while (!vbl_stb_o);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
      finish_run();
    end
  end

  initial begin
    int seed_val, v;
    seed_val = $urandom(32'd4051);
    s = '{HT, HD, HSS, HSE, VT, VBS, VBE, VSS, VSE, 0};
    a = s;
    {mh, ml, mpix, mscan, mframe, mts, mtslat, m_hold, m_vs} = '0;
    e_rd = '0; cyc = 0; last_vbl = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: everything quiet in reset
    chk("R1 rd_data", rd_data, 0);
    chk("R1 levels", {hsync_o, vsync_o, active_o, vblank_o}, 0);
    chk("R1 strobes", {vbl_stb_o, fs_stb_o, vs_stb_o}, 0);
    rst = 1'b0;
    rd(2); chk("R1 scanline after reset", rd_data, 0);
    rd(4); chk("R1 frame after reset", rd_data, 0);
    run(250, 1'b1);
    // R3: scanline one line behind
    wait_pos(0, 0); rd(2); chk("R3 scan on line 0", rd_data, VT - 1);
    wait_pos(HSS + 2, 0); rd(2); chk("R3 scan after hsync", rd_data, 0);
    wait_pos(HSS + 1, VBS - 1); rd(2); chk("R3 scan at vblank", rd_data, VBS - 1);
    // R7: pixel count at first vblank line
    wait_pos(0, VBS); rd(0); chk("R7 pixel at vblank line", rd_data, VBS * HT);
    wait_pos(0, 0); rd(0); chk("R7 pixel at origin", rd_data, 0);
    // R5 / R6: frame start delay sweep and vsync offset
    for (int d = 0; d < 4; d++) begin
      wr(9, d);
      wait_vbl(); wait_vbl();
      run(HT * VT - 2, 1'b0);
      chk("R5 frame start offset", fs_gap, (HT - HSS) + HD + d * HT);
      chk("R6 vsync offset", vs_gap, HT);
    end
    // R8: timestamp copy at vblank
    wait_vbl(); rd(3); chk("R8 timestamp", rd_data, vbl_cyc - 1);
    // R10: coherent pair across the frame increment edge
    wait_pos(HSS, VBS - 1); rd(0); rd(1); v = rd_data; rd(4);
    chk("R10 captured frame", v, rd_data - 1);
    // R9: shadow vtotal change lands at vblank
    wait_vbl(); run(5, 1'b0);
    wr(4, 9); wr(6, 9);
    wait_vbl(); chk("R9 old period", vbl_gap, HT * VT);
    wait_vbl(); chk("R9 new period", vbl_gap, HT * 9);
    rd(7); chk("R11 unmapped address", rd_data, 0);
    run(800, 1'b1);
    finish_run();
  end
endmodule